// File: doc/BRIEF.md
# Asymmetric Duty-Cycle Clock Divider

This block derives a slow converter clock from the system clock. The high phase and the low phase of the derived clock are each set by their own field. A 5-bit setting gives the number of high cycles and a 3-bit setting gives the number of low cycles. The derived clock is produced as a registered level. A companion strobe is one system cycle long and marks each rising edge, so synchronous logic downstream can act on converter-clock edges without treating the level as a clock.

One down counter times both phases. At the start of a high phase it is loaded with the high setting. The high phase ends when a zero detector fires. The counter keeps counting down through the low phase and wraps past zero. The low phase ends when the counter's three low bits equal the bitwise inverse of the low setting, and the counter is then reloaded. The low setting is latched when each high phase begins. A change to either field made in the middle of a period therefore takes effect only at the next rising edge.

A compatibility input is accepted but has no effect on the outputs. The default widths are 5 bits for the high setting and 3 bits for the low setting. The output frequency is the system frequency divided by (high+1)+(low+1). For example, settings 19/7 divide 56 MHz to 2 MHz, and settings 7/7 divide 32 MHz to 2 MHz with a 50% duty cycle.

Top module: `clkdiv_asym`

## Requirements
- R1: While `rst` is sampled high at a clock edge, `div_clk` and `div_rise` are both 0 after that edge.
- R2: At the first clock edge that samples `rst` low, a high phase begins. In the following cycle `div_clk` and `div_rise` are both 1.
- R3: Each high phase lasts exactly H+1 system cycles. H is the value of `hi_set` sampled at the edge where that phase began (0 to 31).
- R4: Each low phase lasts exactly L+1 system cycles. L is the value of `lo_set` sampled at the edge where the preceding high phase began (0 to 7). L=0 gives a single low cycle.
- R5: With steady settings, consecutive rising edges of `div_clk` are H+L+2 system cycles apart.
- R6: `compat_add` has no effect on `div_clk` or `div_rise`, whether it is held at 0, held at 1 or toggled every cycle.
- R7: `div_rise` is 1 for exactly one cycle: the first cycle of each high phase. It is 0 in every other cycle.
- R8: A change to `hi_set` or `lo_set` during a high or a low phase does not alter that phase or the rest of the current period. The new values govern the period that starts at the next rising edge.
- R9: H=0 gives a high phase of exactly one system cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_set | input | HI_W (5) | High-phase setting H; the phase lasts H+1 cycles |
| lo_set | input | LO_W (3) | Low-phase setting L; the phase lasts L+1 cycles |
| compat_add | input | 1 | Compatibility bit, ignored |
| div_clk | output | 1 | Divided clock level |
| div_rise | output | 1 | One-cycle strobe in the first cycle of each high phase |

## Verification
Every one of the 256 combinations of the high and low settings is run for two full periods after a reset. Each cycle's level and strobe are compared with a waveform computed from the phase position. This separates a wrong reload, a wrong zero detect and a wrong inverse compare, because each of those fails at a different combination, notably H=0, L=0 and L=7. Separate runs change the settings in the middle of a high phase and in the middle of a low phase. Those runs show whether the settings are captured at the rising edge or used live. A run with the compatibility bit held and then toggled must match the plain waveform. Resets asserted in the middle of a phase check that the outputs clear and that the restart follows.

// File: rtl/clkdiv_asym_pkg.sv
package clkdiv_asym_pkg;
   typedef enum logic [1:0] {
      PH_ARM  = 2'd0,
      PH_HIGH = 2'd1,
      PH_LOW  = 2'd2
   } phase_e;
endpackage

// File: rtl/clkdiv_asym_cnt.sv
module clkdiv_asym_cnt #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] STEP = 1;

   // free-running decrement; wraps from zero to all ones
   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else
         cnt <= cnt - STEP;
   end
endmodule

// File: rtl/clkdiv_asym_detect.sv
module clkdiv_asym_detect #(
   parameter int HI_W = 5,
   parameter int LO_W = 3
) (
   input  logic [HI_W-1:0] cnt,
   input  logic [LO_W-1:0] lo_q,
   output logic            is_zero,
   output logic            lo_done
);
   generate
      if (LO_W > HI_W) begin : g_width_bad
         $error("clkdiv_asym_detect: LO_W must not exceed HI_W");
      end
      if (LO_W < 1) begin : g_lo_bad
         $error("clkdiv_asym_detect: LO_W must be at least 1");
      end
   endgenerate

   assign is_zero = (cnt == '0);
   // the low phase ends on a match with the inverted setting
   assign lo_done = (cnt[LO_W-1:0] == ~lo_q);
endmodule

// File: rtl/clkdiv_asym_fsm.sv
module clkdiv_asym_fsm
   import clkdiv_asym_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic is_zero,
   input  logic lo_done,
   output logic start,
   output logic div_clk,
   output logic div_rise
);
   phase_e ph_q;
   phase_e ph_d;

   always_comb begin
      start = 1'b0;
      ph_d  = ph_q;
      unique case (ph_q)
         PH_ARM: begin
            start = 1'b1;
            ph_d  = PH_HIGH;
         end
         PH_HIGH: begin
            if (is_zero) ph_d = PH_LOW;
         end
         PH_LOW: begin
            if (lo_done) begin
               start = 1'b1;
               ph_d  = PH_HIGH;
            end
         end
         default: ph_d = PH_ARM;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q     <= PH_ARM;
         div_clk  <= 1'b0;
         div_rise <= 1'b0;
      end else begin
         ph_q     <= ph_d;
         div_clk  <= (ph_d == PH_HIGH);
         div_rise <= start;
      end
   end
endmodule

// File: rtl/clkdiv_asym.sv
module clkdiv_asym #(
   parameter int HI_W = 5,
   parameter int LO_W = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [HI_W-1:0] hi_set,
   input  logic [LO_W-1:0] lo_set,
   input  logic            compat_add,
   output logic            div_clk,
   output logic            div_rise
);
   logic [HI_W-1:0] cnt;
   logic [LO_W-1:0] lo_q;
   logic            is_zero;
   logic            lo_done;
   logic            start;

   // low setting held for the whole period that begins at start
   always_ff @(posedge clk) begin
      if (rst)
         lo_q <= '0;
      else if (start)
         lo_q <= lo_set;
   end

   clkdiv_asym_cnt #(.W(HI_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (start),
      .load_val (hi_set),
      .cnt      (cnt)
   );

   clkdiv_asym_detect #(.HI_W(HI_W), .LO_W(LO_W)) u_det (
      .cnt     (cnt),
      .lo_q    (lo_q),
      .is_zero (is_zero),
      .lo_done (lo_done)
   );

   clkdiv_asym_fsm u_fsm (
      .clk      (clk),
      .rst      (rst),
      .is_zero  (is_zero),
      .lo_done  (lo_done),
      .start    (start),
      .div_clk  (div_clk),
      .div_rise (div_rise)
   );
endmodule

// File: rtl/clkdiv_asym_chk.sv
module clkdiv_asym_chk #(
   parameter int HI_W = 5,
   parameter int LO_W = 3
) (
   input logic            clk,
   input logic            rst,
   input logic [HI_W-1:0] hi_set,
   input logic [LO_W-1:0] lo_set,
   input logic            compat_add,
   input logic            div_clk,
   input logic            div_rise
);
   localparam logic [HI_W:0] ONE_H = 1;
   localparam logic [LO_W:0] ONE_L = 1;

   logic [HI_W-1:0] hi_prev, hi_exp;
   logic [LO_W-1:0] lo_prev, lo_exp;
   logic [HI_W:0]   hi_run;
   logic [LO_W:0]   lo_run;
   logic            seen;

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_prev <= '0;
         lo_prev <= '0;
         hi_exp  <= '0;
         lo_exp  <= '0;
         hi_run  <= '0;
         lo_run  <= '0;
         seen    <= 1'b0;
      end else begin
         hi_prev <= hi_set;
         lo_prev <= lo_set;
         if (div_rise) begin
            hi_exp <= hi_prev;
            lo_exp <= lo_prev;
            seen   <= 1'b1;
         end
         if (div_clk) hi_run <= div_rise ? ONE_H : hi_run + ONE_H;
         if (div_clk) lo_run <= '0;
         else         lo_run <= lo_run + ONE_L;
      end
   end

   p_rst_quiet_r1: assert property (@(posedge clk)
      rst |=> (!div_clk && !div_rise));

   p_arm_start_r2: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |=> (div_clk && div_rise));

   p_high_len_r3: assert property (@(posedge clk) disable iff (rst)
      ($fell(div_clk) && !$past(rst)) |-> (hi_run == {1'b0, hi_exp} + ONE_H));

   p_low_len_r4: assert property (@(posedge clk) disable iff (rst)
      (div_rise && seen) |-> (lo_run == {1'b0, lo_exp} + ONE_L));

   p_legacy_known_r6: assert property (@(posedge clk) disable iff (rst)
      !$isunknown(compat_add));

   p_rise_edge_r7: assert property (@(posedge clk) disable iff (rst)
      div_rise |-> (div_clk && !$past(div_clk)));

   p_rise_single_r7: assert property (@(posedge clk) disable iff (rst)
      div_rise |=> !div_rise);

   p_rise_marks_edge_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(div_clk) |-> div_rise);
endmodule

bind clkdiv_asym clkdiv_asym_chk #(.HI_W(HI_W), .LO_W(LO_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .hi_set     (hi_set),
   .lo_set     (lo_set),
   .compat_add (compat_add),
   .div_clk    (div_clk),
   .div_rise   (div_rise)
);

// File: tb/clkdiv_asym_bench.sv
`timescale 1ns/1ps
module clkdiv_asym_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [4:0] hi_in = '0;
   logic [2:0] lo_in = '0;
   logic       leg = 1'b0;
   logic       div_clk;
   logic       div_rise;
   int         checks = 0;
   int         fails = 0;

   always #5 clk = ~clk;

   clkdiv_asym u_clkdiv_asym (
      .clk        (clk),
      .rst        (rst),
      .hi_set     (hi_in),
      .lo_set     (lo_in),
      .compat_add (leg),
      .div_clk    (div_clk),
      .div_rise   (div_rise)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // R1 during reset, R2 on the first cycle after release
   task automatic do_reset();
      rst = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(posedge clk);
         @(negedge clk);
         chk(!div_clk && !div_rise, "R1", {div_clk, div_rise}, 0);
      end
      rst = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(div_clk && div_rise, "R2", {div_clk, div_rise}, 3);
   endtask

   // entered at the negedge of a rise cycle; leaves at the next one
   task automatic run_wave(input int h, input int l, input int nper, input string tag,
                           input bit tog, input int chg_at, input int nh, input int nl);
      int per;
      int last;
      per  = h + l + 2;
      last = 0;
      for (int i = 0; i < nper * per; i++) begin
         int    p;
         bit    eo;
         bit    er;
         string t;
         p  = i % per;
         eo = (p <= h);
         er = (p == 0);
         if (tag != "") t = tag;
         else if (eo) t = (h == 0) ? "R9" : "R3";
         else t = "R4";
         chk(div_clk == eo, t, int'(div_clk), int'(eo));
         chk(div_rise == er, (tag != "") ? tag : "R7", int'(div_rise), int'(er));
         if (div_rise && i > 0) begin
            chk(i - last == per, "R5", i - last, per);
            last = i;
         end
         if (i == chg_at) begin
            hi_in = nh[4:0];
            lo_in = nl[2:0];
         end
         if (tog) leg = ~leg;
         @(negedge clk);
      end
   endtask

   initial begin
      // full sweep of both settings (R3, R4, R5, R7, R9)
      for (int h = 0; h < 32; h++) begin
         for (int l = 0; l < 8; l++) begin
            hi_in = h[4:0];
            lo_in = l[2:0];
            do_reset();
            run_wave(h, l, 2, "", ((h + l) % 2) == 1, -1, 0, 0);
         end
      end

      // R6: compatibility bit held high, then toggled every cycle
      hi_in = 5'd9;
      lo_in = 3'd2;
      leg   = 1'b1;
      do_reset();
      run_wave(9, 2, 2, "R6", 1'b0, -1, 0, 0);
      run_wave(9, 2, 3, "R6", 1'b1, -1, 0, 0);
      leg = 1'b0;

      // R8: change during a high phase
      hi_in = 5'd5;
      lo_in = 3'd3;
      do_reset();
      run_wave(5, 3, 1, "R8", 1'b0, 2, 20, 0);
      run_wave(20, 0, 2, "R8", 1'b0, -1, 0, 0);

      // R8: change during a low phase
      hi_in = 5'd3;
      lo_in = 3'd6;
      do_reset();
      run_wave(3, 6, 1, "R8", 1'b0, 6, 10, 2);
      run_wave(10, 2, 2, "R8", 1'b0, -1, 0, 0);

      // R1: reset asserted in the middle of a high phase
      hi_in = 5'd12;
      lo_in = 3'd4;
      do_reset();
      repeat (5) @(negedge clk);
      do_reset();
      run_wave(12, 4, 1, "R1", 1'b0, -1, 0, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=200000 expected<200000");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule